// File: doc/BRIEF.md
# Embedded Controller Host Port

This block is the device end of a byte-wide host port that gives a host processor access to an 8-bit internal register space. The host sees two ports. The data port carries address bytes, data bytes and returned bytes. The control port returns a status byte on a read and takes a command byte on a write. The host paces every transfer with two flags in the status byte. An input-full flag means the controller has not yet taken the last byte the host wrote. An output-full flag means a returned byte is waiting in the data port.

Each accepted byte is consumed after a configurable latency. This lets polling host code be tested against a slow controller. Command bytes are decoded into five operations: read, write, burst on, burst off and query. Read and write collect an address byte, and write also collects a data byte, from the data port. The block then makes a single-cycle access on a simple internal register bus. A read result, the burst acknowledge and the query event byte are all returned through the output buffer.

Top module: `ec_host_if`

## Requirements
- R1: After reset the status byte reads 0x00, no output byte is pending and no register access is made.
- R2: A host write to either port sets input-full (status bit 1) on the next cycle. Status bit 3 then reads 1 if the byte went to the control port (`host_sel`=1) and 0 if it went to the data port.
- R3: Input-full stays set for exactly `LAT_CYCLES` cycles after the write, then clears when the byte is consumed.
- R4: When the controller loads a byte for the host, output-full (status bit 0) sets and the data port reads that byte. A data-port read (`host_rd` with `host_sel`=0) clears output-full on the next cycle.
- R5: Command 0x80 followed by one address byte makes one `reg_rd` strobe at that address, and the value read is returned through the output buffer.
- R6: Command 0x81 followed by an address byte and a data byte makes one `reg_wr` strobe carrying that address and that data.
- R7: `reg_rd` and `reg_wr` are never high together, and each consumed byte causes at most one access.
- R8: Command 0x82 sets the burst flag (status bit 4) and returns the byte 0x90. Command 0x83 clears the burst flag and returns no byte.
- R9: Command 0x84 returns the value on `evt_byte` through the output buffer.
- R10: A command byte that arrives in the middle of a read or write sequence abandons that sequence, and the new command is decoded in its place.
- R11: A data-port byte consumed while no command is active is discarded: it causes no register access and no output byte.
- R12: Status bits 2, 5, 6 and 7 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 1 | Port select: 0 data port, 1 status/command port |
| host_wr | input | 1 | One-cycle host write strobe |
| host_rd | input | 1 | One-cycle host read strobe |
| host_wdata | input | 8 | Byte written by the host |
| host_rdata | output | 8 | Data byte or status byte, selected by `host_sel` |
| evt_byte | input | 8 | Event byte returned by the query command |
| reg_rd | output | 1 | Internal register read strobe |
| reg_wr | output | 1 | Internal register write strobe |
| reg_addr | output | 8 | Internal register address |
| reg_wdata | output | 8 | Internal register write data |
| reg_rdata | input | 8 | Internal register read data, sampled during `reg_rd` |

## Verification
The bench counts the cycles for which input-full stays high. A counter that is off by one would show a hold time other than `LAT_CYCLES`. It issues a read command partway through a write sequence. A design that did not abandon the old sequence would write to the first address, or treat the second address as write data. It sends stray data-port bytes while no command is active and counts every bus strobe. A decoder that treats the idle state as a read would produce an extra access or an unexpected output byte. The random accesses check every read result against a bench copy of the register space, so misrouted addresses or data show up as mismatches.

// File: rtl/ec_hif_pkg.sv
package ec_hif_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE    = 2'd0,
        SQ_RD_ADDR = 2'd1,
        SQ_WR_ADDR = 2'd2,
        SQ_WR_DATA = 2'd3
    } seq_e;

    localparam logic [7:0] OP_READ      = 8'h80;
    localparam logic [7:0] OP_WRITE     = 8'h81;
    localparam logic [7:0] OP_BURST_ON  = 8'h82;
    localparam logic [7:0] OP_BURST_OFF = 8'h83;
    localparam logic [7:0] OP_QUERY     = 8'h84;
    localparam logic [7:0] BURST_ACK    = 8'h90;

    localparam int ST_OBF   = 0;
    localparam int ST_IBF   = 1;
    localparam int ST_CMD   = 3;
    localparam int ST_BURST = 4;

endpackage

// File: rtl/ec_hif_inbuf.sv
module ec_hif_inbuf #(
    parameter int LAT_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_wr,
    input  logic       host_sel,
    input  logic [7:0] host_wdata,
    output logic       ibf,
    output logic       is_cmd,
    output logic [7:0] byte_q,
    output logic       consume
);
    localparam int CW = $clog2(LAT_CYCLES + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [7:0]    b;
        logic          cmd;
    } ib_t;

    ib_t ib_d, ib_q;

    always_comb begin
        ib_d = ib_q;
        if (ib_q.cnt != '0) begin
            ib_d.cnt = ib_q.cnt - 1'b1;
        end
        if (host_wr) begin
            ib_d.cnt = CW'(LAT_CYCLES);
            ib_d.b   = host_wdata;
            ib_d.cmd = host_sel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ib_q <= '0;
        end else begin
            ib_q <= ib_d;
        end
    end

    assign ibf     = (ib_q.cnt != '0);
    assign is_cmd  = ib_q.cmd;
    assign byte_q  = ib_q.b;
    assign consume = (ib_q.cnt == CW'(1)) && !host_wr;

    // R2: a host write raises input-full on the following cycle
    a_r2_ibf_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr |=> ibf);

    // R3: input-full holds until the byte is consumed
    a_r3_ibf_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ibf && !consume && !host_wr) |=> ibf);

endmodule

// File: rtl/ec_hif_outbuf.sv
module ec_hif_outbuf (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] load_byte,
    input  logic       host_rd,
    input  logic       host_sel,
    output logic       obf,
    output logic [7:0] data_q
);
    typedef struct packed {
        logic       full;
        logic [7:0] data;
    } ob_t;

    ob_t ob_d, ob_q;

    always_comb begin
        ob_d = ob_q;
        if (host_rd && !host_sel) begin
            ob_d.full = 1'b0;
        end
        if (load) begin
            ob_d.full = 1'b1;
            ob_d.data = load_byte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ob_q <= '0;
        end else begin
            ob_q <= ob_d;
        end
    end

    assign obf    = ob_q.full;
    assign data_q = ob_q.data;

    // R4: a data-port read with no new load empties the buffer
    a_r4_obf_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !host_sel && !load) |=> !obf);

    // R4: a load always leaves the buffer full
    a_r4_obf_set: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> obf);

endmodule

// File: rtl/ec_hif_seq.sv
module ec_hif_seq
    import ec_hif_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       consume,
    input  logic       is_cmd,
    input  logic [7:0] byte_in,
    input  logic [7:0] evt_byte,
    input  logic [7:0] reg_rdata,
    output logic       reg_rd,
    output logic       reg_wr,
    output logic [7:0] reg_addr,
    output logic [7:0] reg_wdata,
    output logic       ob_load,
    output logic [7:0] ob_byte,
    output logic       burst
);
    typedef struct packed {
        seq_e       st;
        logic [7:0] addr;
        logic       burst;
    } sq_t;

    sq_t sq_d, sq_q;

    always_comb begin
        sq_d      = sq_q;
        reg_rd    = 1'b0;
        reg_wr    = 1'b0;
        reg_addr  = sq_q.addr;
        reg_wdata = byte_in;
        ob_load   = 1'b0;
        ob_byte   = reg_rdata;
        if (consume) begin
            if (is_cmd) begin
                sq_d.st = SQ_IDLE;
                case (byte_in)
                    OP_READ:      sq_d.st = SQ_RD_ADDR;
                    OP_WRITE:     sq_d.st = SQ_WR_ADDR;
                    OP_BURST_ON: begin
                        sq_d.burst = 1'b1;
                        ob_load    = 1'b1;
                        ob_byte    = BURST_ACK;
                    end
                    OP_BURST_OFF: sq_d.burst = 1'b0;
                    OP_QUERY: begin
                        ob_load = 1'b1;
                        ob_byte = evt_byte;
                    end
                    default: ;
                endcase
            end else begin
                case (sq_q.st)
                    SQ_RD_ADDR: begin
                        reg_addr = byte_in;
                        reg_rd   = 1'b1;
                        ob_load  = 1'b1;
                        ob_byte  = reg_rdata;
                        sq_d.st  = SQ_IDLE;
                    end
                    SQ_WR_ADDR: begin
                        sq_d.addr = byte_in;
                        sq_d.st   = SQ_WR_DATA;
                    end
                    SQ_WR_DATA: begin
                        reg_wr  = 1'b1;
                        sq_d.st = SQ_IDLE;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sq_q <= '{st: SQ_IDLE, addr: 8'h00, burst: 1'b0};
        end else begin
            sq_q <= sq_d;
        end
    end

    assign burst = sq_q.burst;

    // R7: never a read and a write strobe together
    a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rd && reg_wr));

    // R7: a strobe only on a consumed byte
    a_r7_strobe_on_consume: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd || reg_wr) |-> consume);

    // R8: burst-on command sets the flag
    a_r8_burst_set: assert property (@(posedge clk) disable iff (!rst_n)
        (consume && is_cmd && byte_in == OP_BURST_ON) |=> burst);

    // R11: stray data byte leaves the sequencer idle
    a_r11_idle_data_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (consume && !is_cmd && sq_q.st == SQ_IDLE) |=> (sq_q.st == SQ_IDLE));

    // R10: any command byte ends the sequence it interrupts
    a_r10_cmd_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (consume && is_cmd && byte_in != OP_READ && byte_in != OP_WRITE)
        |=> (sq_q.st == SQ_IDLE));

endmodule

// File: rtl/ec_host_if.sv
module ec_host_if
    import ec_hif_pkg::*;
#(
    parameter int LAT_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_sel,
    input  logic       host_wr,
    input  logic       host_rd,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    input  logic [7:0] evt_byte,
    output logic       reg_rd,
    output logic       reg_wr,
    output logic [7:0] reg_addr,
    output logic [7:0] reg_wdata,
    input  logic [7:0] reg_rdata
);
    logic       ibf, is_cmd, consume;
    logic [7:0] in_byte;
    logic       ob_load, obf, burst;
    logic [7:0] ob_byte, out_byte;
    logic [7:0] status;

    ec_hif_inbuf #(.LAT_CYCLES(LAT_CYCLES)) u_inbuf (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_sel   (host_sel),
        .host_wdata (host_wdata),
        .ibf        (ibf),
        .is_cmd     (is_cmd),
        .byte_q     (in_byte),
        .consume    (consume)
    );

    ec_hif_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .consume   (consume),
        .is_cmd    (is_cmd),
        .byte_in   (in_byte),
        .evt_byte  (evt_byte),
        .reg_rdata (reg_rdata),
        .reg_rd    (reg_rd),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .ob_load   (ob_load),
        .ob_byte   (ob_byte),
        .burst     (burst)
    );

    ec_hif_outbuf u_outbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ob_load),
        .load_byte (ob_byte),
        .host_rd   (host_rd),
        .host_sel  (host_sel),
        .obf       (obf),
        .data_q    (out_byte)
    );

    always_comb begin
        status           = 8'h00;
        status[ST_OBF]   = obf;
        status[ST_IBF]   = ibf;
        status[ST_CMD]   = is_cmd;
        status[ST_BURST] = burst;
    end

    assign host_rdata = host_sel ? status : out_byte;

    // R12: unused status bits stay low
    a_r12_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (host_sel -> (host_rdata & 8'hE4) == 8'h00));

endmodule

// File: tb/ec_host_if_tb_top.sv
`timescale 1ns/1ps
module ec_host_if_tb_top;
    localparam int LAT = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_sel = 1'b1;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic [7:0] evt_byte = 8'hC3;
    logic       reg_rd, reg_wr;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;

    logic [7:0] mem [256];
    logic [7:0] expm [256];
    int rd_cnt = 0, wr_cnt = 0, both_cnt = 0;
    int total = 0, bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    ec_host_if #(.LAT_CYCLES(LAT)) dut_i (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .evt_byte(evt_byte), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    function automatic logic [7:0] seed_val(input int i);
        return 8'(i) ^ 8'h5A;
    endfunction

    assign reg_rdata = mem[reg_addr];

    always @(posedge clk) begin
        if (reg_wr) mem[reg_addr] <= reg_wdata;
        if (reg_rd) rd_cnt <= rd_cnt + 1;
        if (reg_wr) wr_cnt <= wr_cnt + 1;
        if (reg_rd && reg_wr) both_cnt <= both_cnt + 1;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
        end
    endtask

    task automatic get_status(output logic [7:0] s);
        host_sel = 1'b1;
        #1 s = host_rdata;
    endtask

    task automatic hwr(input bit sel, input logic [7:0] b);
        @(negedge clk);
        host_sel = sel; host_wdata = b; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; host_sel = 1'b1;
    endtask

    task automatic wait_ibf();
        logic [7:0] s;
        get_status(s);
        while (s[1]) begin
            @(negedge clk);
            get_status(s);
        end
    endtask

    task automatic wait_obf();
        logic [7:0] s;
        int n = 0;
        get_status(s);
        while (!s[0] && n < 50) begin
            @(negedge clk);
            get_status(s);
            n++;
        end
    endtask

    task automatic hrd_data(output logic [7:0] b);
        @(negedge clk);
        host_sel = 1'b0;
        #1 b = host_rdata;
        host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0; host_sel = 1'b1;
    endtask

    task automatic ec_write(input logic [7:0] a, input logic [7:0] d);
        wait_ibf(); hwr(1'b1, 8'h81);
        wait_ibf(); hwr(1'b0, a);
        wait_ibf(); hwr(1'b0, d);
        wait_ibf();
    endtask

    task automatic ec_read(input logic [7:0] a, output logic [7:0] d);
        wait_ibf(); hwr(1'b1, 8'h80);
        wait_ibf(); hwr(1'b0, a);
        wait_ibf(); wait_obf();
        hrd_data(d);
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 150000 && !finished) begin
            @(posedge clk);
            cyc++;
        end
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected<%0d", cyc, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] s, d;
        int n, w0, r0;
        for (int i = 0; i < 256; i++) begin
            mem[i]  = seed_val(i);
            expm[i] = seed_val(i);
        end
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        get_status(s);
        chk(s == 8'h00, "R1 status after reset", s, 8'h00);
        chk(rd_cnt == 0 && wr_cnt == 0, "R1 no access after reset", rd_cnt + wr_cnt, 0);

        // R2, R3, R12: command write raises IBF and CMD, IBF hold time
        hwr(1'b1, 8'h80);
        get_status(s);
        chk(s == 8'h0A, "R2 status after command write", s, 8'h0A);
        n = 0;
        while (s[1] && n < 20) begin
            n++;
            @(negedge clk);
            get_status(s);
        end
        chk(n == LAT, "R3 IBF hold cycles", n, LAT);
        // R2: data-port write clears the command bit
        hwr(1'b0, 8'h10);
        get_status(s);
        chk(s[1] == 1'b1 && s[3] == 1'b0, "R2 status after data write", s, 8'h02);
        wait_ibf(); wait_obf();
        get_status(s);
        chk(s[0] == 1'b1, "R4 OBF set after read", s, 8'h01);
        chk((s & 8'hE4) == 8'h00, "R12 reserved bits", s & 8'hE4, 0);
        hrd_data(d);
        chk(d == expm[8'h10], "R5 read result", d, expm[8'h10]);
        @(negedge clk);
        get_status(s);
        chk(s[0] == 1'b0, "R4 OBF cleared by data read", s[0], 0);
        chk(rd_cnt == 1, "R5 single read strobe", rd_cnt, 1);

        // R6: directed write then readback
        w0 = wr_cnt;
        ec_write(8'hFF, 8'hA7); expm[8'hFF] = 8'hA7;
        chk(wr_cnt == w0 + 1, "R6 single write strobe", wr_cnt, w0 + 1);
        ec_read(8'hFF, d);
        chk(d == 8'hA7, "R6 write readback", d, 8'hA7);

        // R8: burst on / off
        wait_ibf(); hwr(1'b1, 8'h82); wait_ibf(); wait_obf();
        get_status(s);
        chk(s[4] == 1'b1, "R8 burst flag set", s, 8'h10);
        hrd_data(d);
        chk(d == 8'h90, "R8 burst acknowledge", d, 8'h90);
        wait_ibf(); hwr(1'b1, 8'h83); wait_ibf();
        @(negedge clk);
        get_status(s);
        chk(s[4] == 1'b0 && s[0] == 1'b0, "R8 burst cleared, no byte", s, 8'h00);

        // R9: query
        evt_byte = 8'h3C;
        wait_ibf(); hwr(1'b1, 8'h84); wait_ibf(); wait_obf();
        hrd_data(d);
        chk(d == 8'h3C, "R9 query byte", d, 8'h3C);

        // R10: read command aborts a write sequence
        w0 = wr_cnt;
        wait_ibf(); hwr(1'b1, 8'h81);
        wait_ibf(); hwr(1'b0, 8'h20);
        wait_ibf(); hwr(1'b1, 8'h80);
        wait_ibf(); hwr(1'b0, 8'h21);
        wait_ibf(); wait_obf();
        hrd_data(d);
        chk(d == expm[8'h21], "R10 aborting read result", d, expm[8'h21]);
        chk(wr_cnt == w0, "R10 aborted write not done", wr_cnt, w0);
        ec_read(8'h20, d);
        chk(d == expm[8'h20], "R10 first address untouched", d, expm[8'h20]);

        // R11: stray data bytes while idle
        w0 = wr_cnt; r0 = rd_cnt;
        wait_ibf(); hwr(1'b0, 8'h55);
        wait_ibf(); hwr(1'b0, 8'h81);
        wait_ibf();
        @(negedge clk);
        get_status(s);
        chk(s[0] == 1'b0, "R11 no output byte", s[0], 0);
        chk(wr_cnt == w0 && rd_cnt == r0, "R11 no register access", wr_cnt + rd_cnt, w0 + r0);

        // R5, R6: random accesses
        for (int k = 0; k < 40; k++) begin
            logic [7:0] a, v;
            a = 8'($urandom_range(0, 255));
            if ($urandom_range(0, 1) == 1) begin
                v = 8'($urandom);
                ec_write(a, v);
                expm[a] = v;
            end else begin
                ec_read(a, d);
                chk(d == expm[a], "R5 random read", d, expm[a]);
            end
        end

        // R7: no overlapping strobes seen
        chk(both_cnt == 0, "R7 strobes exclusive", both_cnt, 0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule